// File: doc/BRIEF.md
# Half-Buffered Byte Cipher Sequencer

This block holds one 128-byte message at a time in a 256-byte two-port memory and runs it through a chained byte cipher. An upstream byte source writes the message into the lower half through a valid/ready input stream. The block then waits for a start command that carries the mode (encrypt or decrypt) and an 8-bit key. On start it reads the lower half one byte per cycle, passes each byte through the cipher core and stores the result in the upper half. The upper half is filled from the highest address downward. Last, it reads the upper half back, again from the top downward, and offers the bytes on a valid/ready output stream. Bytes therefore leave in the order they arrived.

The cipher core works on one byte per step and carries a chain byte from step to step. Encryption XORs the plain byte with the chain byte and then swaps the two nibbles. The result is sent out and also becomes the next chain byte. Decryption swaps the nibbles of the cipher byte and then XORs with the chain byte. The incoming cipher byte becomes the next chain byte. Both streams apply back-pressure in the usual way. On the input, a byte is taken only on a cycle where `in_valid` and `in_ready` are both high. On the output, `out_data` is offered while `out_valid` is high and is held until the receiver raises `out_ready`.

Top module: `halfbuf_cipher_seq`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: Accepted input bytes are stored at lower-half addresses 0, 1, 2 and so on, in arrival order. After the 128th byte is accepted, `in_ready` stays 0 until the block returns to idle.
- R3: `start` has no effect before all 128 input bytes have arrived. No output appears and input acceptance continues.
- R4: With `mode_dec`=0, each result is the nibble swap of (input byte XOR chain), and that result becomes the new chain byte.
- R5: With `mode_dec`=1, each result is (nibble swap of the input byte) XOR chain, and the input byte becomes the new chain byte. Decrypting a ciphertext with the key that produced it returns the plaintext.
- R6: The chain byte is loaded from `key` at every start, so each message is processed independently of the previous one.
- R7: Result i is written at address 255−i. Read-back walks from 255 down to 128, so exactly 128 bytes are output, in input order.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R9: `done` is 1 for exactly one cycle, in the cycle after the 128th output byte is accepted. In the cycle after that the block is idle with `in_ready`=1, and the next message is stored again from address 0.
- R10: `mode_dec` and `key` are sampled only in the cycle where `start` is accepted. Changing them later has no effect on the running message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Input stream byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte (idle or filling) |
| start | input | 1 | Begin processing; honoured only once the message is complete |
| mode_dec | input | 1 | 0 = encrypt, 1 = decrypt; sampled with start |
| key | input | 8 | Initial chain byte; sampled with start |
| out_data | output | 8 | Output stream byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| done | output | 1 | One-cycle pulse after the last output byte is taken |

## Verification
On every cycle, the assertions check the following:
- input writes land only in the lower half and never beyond 128 bytes;
- processing writes land only in the upper half;
- a stalled output byte holds its value;
- output appears only during the send phase;
- `done` lasts a single cycle and is followed by idle.

Other properties can only be shown by the bench scenarios. These are the cipher arithmetic in both modes, the reversed storage and downward read-back that restore byte order, the reload of the key per message, and the insensitivity to early `start` and to late changes of mode and key. The bench checks them by comparing whole messages, sent with gaps and with output stalls, against a reference model.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_WAIT,
    PH_PROC,
    PH_SEND,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/hbc_mem.sv
module hbc_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // registered read, updated only when a read is requested
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/hbc_core.sv
module hbc_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] key,
  input  logic          dec_in,
  input  logic          step,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int H = DW / 2;

  logic [DW-1:0] chain_q;
  logic          dec_q;
  logic [DW-1:0] mixed;
  logic [DW-1:0] swapped_in;

  assign swapped_in = {din[H-1:0], din[DW-1:H]};
  assign mixed      = din ^ chain_q;

  always_comb begin
    if (dec_q) dout = swapped_in ^ chain_q;
    else       dout = {mixed[H-1:0], mixed[DW-1:H]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      dec_q   <= 1'b0;
    end else if (load) begin
      chain_q <= key;
      dec_q   <= dec_in;
    end else if (step) begin
      chain_q <= dec_q ? din : dout;
    end
  end
endmodule

// File: rtl/halfbuf_cipher_seq.sv
module halfbuf_cipher_seq #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          start,
  input  logic          mode_dec,
  input  logic [DW-1:0] key,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          done
);
  import hbc_pkg::*;

  localparam int          HALF   = 2 ** (AW - 1);
  localparam logic [AW-1:0] HALF_V = AW'(HALF);
  localparam logic [AW-1:0] LAST_V = AW'(HALF - 1);
  localparam logic [AW-1:0] TOP_V  = AW'(2 ** AW - 1);

  phase_t        phase_q;
  logic [AW-1:0] wcnt_q;   // input bytes stored
  logic [AW-1:0] rcnt_q;   // processing reads issued
  logic [AW-1:0] pidx_q;   // index of byte returned by memory
  logic          pv_q;     // memory read data valid for processing
  logic [AW-1:0] scnt_q;   // send reads completed
  logic          fetch_q;  // send read in flight
  logic          oval_q;

  logic          accept, rd_issue, snd_issue, load;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata, core_out;

  assign in_ready  = (phase_q == PH_IDLE) || (phase_q == PH_FILL);
  assign accept    = in_valid && in_ready;
  assign load      = (phase_q == PH_WAIT) && start;
  assign rd_issue  = (phase_q == PH_PROC) && (rcnt_q < HALF_V);
  assign snd_issue = (phase_q == PH_SEND) && !oval_q && !fetch_q && (scnt_q < HALF_V);

  assign mem_we    = accept || pv_q;
  assign mem_waddr = accept ? {1'b0, wcnt_q[AW-2:0]} : TOP_V - pidx_q;
  assign mem_wdata = accept ? in_data : core_out;
  assign mem_re    = rd_issue || snd_issue;
  assign mem_raddr = (phase_q == PH_PROC) ? rcnt_q : TOP_V - scnt_q;

  assign out_data  = mem_rdata;
  assign out_valid = oval_q;
  assign done      = (phase_q == PH_DONE);

  hbc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  hbc_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .key(key), .dec_in(mode_dec),
    .step(pv_q), .din(mem_rdata), .dout(core_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      pidx_q  <= '0;
      pv_q    <= 1'b0;
      scnt_q  <= '0;
      fetch_q <= 1'b0;
      oval_q  <= 1'b0;
    end else begin
      pv_q    <= rd_issue;
      fetch_q <= snd_issue;
      if (rd_issue) begin
        rcnt_q <= rcnt_q + 1'b1;
        pidx_q <= rcnt_q;
      end
      case (phase_q)
        PH_IDLE, PH_FILL: begin
          if (accept) begin
            wcnt_q  <= wcnt_q + 1'b1;
            phase_q <= (wcnt_q == LAST_V) ? PH_WAIT : PH_FILL;
          end
        end
        PH_WAIT: begin
          if (start) begin
            phase_q <= PH_PROC;
            rcnt_q  <= '0;
          end
        end
        PH_PROC: begin
          if (pv_q && pidx_q == LAST_V) begin
            phase_q <= PH_SEND;
            scnt_q  <= '0;
          end
        end
        PH_SEND: begin
          if (fetch_q) begin
            oval_q <= 1'b1;
            scnt_q <= scnt_q + 1'b1;
          end else if (oval_q && out_ready) begin
            oval_q <= 1'b0;
            if (scnt_q == HALF_V) phase_q <= PH_DONE;
          end
        end
        PH_DONE: begin
          phase_q <= PH_IDLE;
          wcnt_q  <= '0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2: input writes stay in the lower half and never exceed one message
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (wcnt_q < HALF_V) && !mem_waddr[AW-1]);

  // R7: processed bytes only ever land in the upper half
  a_r7_upper_write: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> mem_waddr[AW-1]);

  // R8: a stalled output byte is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3: no output outside the send phase
  a_r3_out_in_send: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phase_q == PH_SEND));

  // R9: done lasts one cycle and is followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));
endmodule

// File: tb/halfbuf_cipher_seq_test.sv
module halfbuf_cipher_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       start = 1'b0;
  logic       mode_dec = 1'b0;
  logic [7:0] key = '0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       done;

  always #4 clk = ~clk;

  halfbuf_cipher_seq uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .start(start), .mode_dec(mode_dec), .key(key),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cap [128];
  int   got = 0;
  int   done_chk = 0;
  bit   stall_en = 1'b0;
  bit   hold_pend = 1'b0;
  logic [7:0] hold_d = '0;
  int   cyc = 0;
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] swp(input logic [7:0] x);
    return {x[3:0], x[7:4]};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (done_chk == 1) begin
      chk(done == 1'b1, "R9", done, 1);
      done_chk = 2;
    end else if (done_chk == 2) begin
      chk(done == 1'b0 && in_ready == 1'b1, "R9", {done, in_ready}, 1);
      done_chk = 0;
    end
    if (hold_pend) begin
      chk(out_valid && out_data == hold_d, "R8", out_data, hold_d);
      hold_pend = 1'b0;
    end
    out_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", out_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, cur_req, out_data, e);
        if (got < 128) cap[got] = out_data;
        got++;
        if (got == 128) done_chk = 1;
      end
    end else if (out_valid) begin
      hold_pend = 1'b1;
      hold_d = out_data;
    end
  end

  // driver: sends a message, optionally pokes start early (R3)
  task automatic send_msg(input logic [7:0] msg [128], input bit early);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (early && i == 100) begin
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R3", {out_valid, in_ready}, 1);
      end
      if (i % 5 == 4) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = msg[i];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R2", {in_ready, out_valid}, 0);
  endtask

  // pushes expected results, starts, then disturbs mode and key (R10)
  task automatic run_msg(input logic [7:0] msg [128], input logic [7:0] k,
                         input bit dec, input bit early, input string req);
    logic [7:0] ch;
    send_msg(msg, early);
    ch = k;  // R6: chain restarts from key
    for (int i = 0; i < 128; i++) begin
      logic [7:0] r;
      if (dec) begin
        r = swp(msg[i]) ^ ch;
        ch = msg[i];
      end else begin
        r = swp(msg[i] ^ ch);
        ch = r;
      end
      exp_q.push_back(r);
    end
    got = 0;
    cur_req = req;
    @(negedge clk);
    start = 1'b1; mode_dec = dec; key = k;
    @(negedge clk);
    start = 1'b0; mode_dec = ~dec; key = ~k;  // R10
    while (!(got == 128 && done_chk == 0)) @(negedge clk);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
  endtask

  task automatic run_all();
    logic [7:0] p1 [128];
    logic [7:0] c1 [128];
    logic [7:0] p3 [128];
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1",
        {in_ready, out_valid, done}, 3'b100);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) begin
      p1[i] = 8'(i * 7 + 3);
      p3[i] = 8'((i * 29) ^ 8'h5a);
    end
    stall_en = 1'b1;
    run_msg(p1, 8'hc3, 1'b0, 1'b1, "R4");
    for (int i = 0; i < 128; i++) c1[i] = cap[i];
    // R6 and R9: second message from address 0 with a fresh chain
    run_msg(c1, 8'hc3, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 128; i++)
      chk(cap[i] == p1[i], "R5", cap[i], p1[i]);
    stall_en = 1'b0;
    run_msg(p3, 8'h1e, 1'b1, 1'b0, "R6");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule